// File: doc/BRIEF.md
# Multi-Slot Interrupt Aggregation Controller

This block gathers interrupt requests from four plug-in I/O module slots. Each slot drives two independent active-low request lines. The block combines them into one shared active-low host interrupt line. Each request line passes through a two-stage synchronizer. A pending register shows the synchronized state of every line, whatever the enable setting. One enable bit per slot gates both of that slot's lines onto the host line. A separate enable lets a sticky access-timeout status drive the host line as well. Software clears that status by writing a one to it.

A small state machine owns the host line and the service select outputs. It has three states:
- `ST_IDLE`: the host line is released.
- `ST_RAISED`: the host line is driven low.
- `ST_ACK`: the host line stays low, and the selected slot's active-low select plus a line-select bit show which request is being serviced.

Transitions:
- `ST_IDLE -> ST_RAISED` when any enabled source is present.
- `ST_RAISED -> ST_IDLE` when no enabled source remains.
- `ST_RAISED -> ST_ACK` on an acknowledge. The slot and line are captured at this point.
- `ST_ACK -> ST_RAISED` when the acknowledge drops and sources remain.
- `ST_ACK -> ST_IDLE` when the acknowledge drops and no source remains.

Register map (16-bit data, 2-bit address):

| Address | Name | Contents | Access |
|---|---|---|---|
| 0 | control | bits [3:0] are the slot enables; bit 8 is the timeout enable | read/write |
| 1 | pending | bits [7:0] are the request lines; bit 15 is the summary bit | read only |
| 2 | status | bit 0 is the timeout status | write 1 to clear |
| 3 | unused | reads 0 | — |

Top module: `intagg_top`

## Requirements
- R1: After reset `irq_n` is 1, `sel_n` is all ones, and the control and status registers read 0.
- R2: Pending register (address 1) bit 2*s+r reads 1 exactly when `req_n[2*s+r]` (slot s, line r) is low, independent of enables. It follows an input change two clock edges later.
- R3: A slot's two lines affect `irq_n` only while control bit s (address 0, bits [3:0]) is 1.
- R4: `irq_n` falls on the clock edge after an enabled source is present. For a request input this is the third edge after the input changes.
- R5: `irq_n` stays low while any enabled source remains. It rises on the edge after the last enabled source is removed.
- R6: Pending register bit 15 reads 1 exactly when `irq_n` is low.
- R7: Timeout status (address 2, bit 0) sets on the edge where `timeout_evt` is 1 and stays set. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged. When a set event and a clear write fall in the same cycle, the set wins.
- R8: Timeout status drives `irq_n` low only while the timeout enable (address 0, bit 8) is 1.
- R9: While `irq_n` is low, sampling `ack_valid` high selects a slot from the edge where it is sampled. The outputs then show `sel_n[ack_slot]`=0 (all other `sel_n` bits 1) and `sel_line`=`ack_line`. They hold until the edge where `ack_valid` is sampled low, which returns `sel_n` to all ones.
- R10: `ack_valid` while `irq_n` is high is ignored, and `sel_n` stays all ones.
- R11: Address 3 reads 0. Writes to the pending register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 8 | Active-low module requests, bit 2*slot+line |
| timeout_evt | input | 1 | One-cycle access-timeout event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on address) |
| ack_valid | input | 1 | Acknowledge cycle in progress |
| ack_slot | input | 2 | Slot being acknowledged |
| ack_line | input | 1 | Request line being acknowledged |
| irq_n | output | 1 | Active-low shared host interrupt |
| sel_n | output | 4 | Active-low per-slot service select |
| sel_line | output | 1 | Line select during acknowledge |

## Verification
Each result has a fixed latency:
- A request input shows in the pending register after two edges and reaches `irq_n` on the third.
- A register write or timeout event updates its register at the edge it is sampled, and `irq_n` follows one edge later.
- Select outputs change at the edge that samples `ack_valid`.

The bench drives inputs one nanosecond after an edge and counts edges before each check. It also checks the cycle just before a result is due, to confirm the output has not moved early. Read data is sampled after a short settle time within the same cycle.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
    localparam int N_SLOTS   = 4;
    localparam int N_LINES   = 2;
    localparam int N_REQ     = N_SLOTS * N_LINES;
    localparam int SLOT_W    = $clog2(N_SLOTS);
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PEND = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STS  = 2'd2;

    localparam int TO_EN_BIT   = 8;
    localparam int SUMMARY_BIT = 15;
    localparam int TO_STS_BIT  = 0;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAISED = 2'd1,
        ST_ACK    = 2'd2
    } agg_state_t;
endpackage

// File: rtl/intagg_sync.sv
module intagg_sync #(
    parameter int WIDTH  = intagg_pkg::N_REQ,
    parameter int STAGES = intagg_pkg::SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req_n,
    output logic [WIDTH-1:0] pend
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[k] <= '0;
                    else        stage_q[k] <= ~req_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[k] <= '0;
                    else        stage_q[k] <= stage_q[k-1];
                end
            end
        end
    endgenerate

    assign pend = stage_q[STAGES-1];

    // R2: a pending bit moves only after the first stage held the same value
    a_r2_sync_order: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != $past(pend)) |-> (pend == $past(stage_q[STAGES-1 > 0 ? STAGES-2 : 0])))
        else $error("R2 synchronizer order");
endmodule

// File: rtl/intagg_regs.sv
module intagg_regs
    import intagg_pkg::*;
#(
    parameter int SLOTS = N_SLOTS,
    parameter int REQS  = N_REQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REQS-1:0]   pend,
    input  logic              irq_on,
    input  logic              timeout_evt,
    output logic [DATA_W-1:0] rdata,
    output logic [SLOTS-1:0]  slot_en,
    output logic              to_en,
    output logic              to_sts
);
    logic wr_ctrl, clr_sts;

    assign wr_ctrl = wr && (addr == ADDR_CTRL);
    assign clr_sts = wr && (addr == ADDR_STS) && wdata[TO_STS_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_en <= '0;
            to_en   <= 1'b0;
        end else if (wr_ctrl) begin
            slot_en <= wdata[SLOTS-1:0];
            to_en   <= wdata[TO_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           to_sts <= 1'b0;
        else if (timeout_evt) to_sts <= 1'b1;
        else if (clr_sts)     to_sts <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL: begin
                rdata[SLOTS-1:0] = slot_en;
                rdata[TO_EN_BIT] = to_en;
            end
            ADDR_PEND: begin
                rdata[REQS-1:0]    = pend;
                rdata[SUMMARY_BIT] = irq_on;
            end
            ADDR_STS:  rdata[TO_STS_BIT] = to_sts;
            default:   rdata = '0;
        endcase
    end

    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |=> to_sts) else $error("R7 set");
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sts && !timeout_evt) |=> !to_sts) else $error("R7 clear");
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (to_sts && !clr_sts) |=> to_sts) else $error("R7 sticky");
endmodule

// File: rtl/intagg_fsm.sv
module intagg_fsm
    import intagg_pkg::*;
#(
    parameter int SLOTS = N_SLOTS,
    parameter int LINES = N_LINES,
    parameter int SW    = SLOT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOTS*LINES-1:0] pend,
    input  logic [SLOTS-1:0]       slot_en,
    input  logic                   to_en,
    input  logic                   to_sts,
    input  logic                   ack_valid,
    input  logic [SW-1:0]          ack_slot,
    input  logic                   ack_line,
    output logic                   irq_n,
    output logic                   irq_on,
    output logic [SLOTS-1:0]       sel_n,
    output logic                   sel_line
);
    agg_state_t       state_q, state_d;
    logic [SW-1:0]    slot_q;
    logic             line_q;
    logic [SLOTS-1:0] slot_hit;
    logic             any_src;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_hit
            assign slot_hit[s] = slot_en[s] & (|pend[s*LINES +: LINES]);
        end
    endgenerate

    assign any_src = (|slot_hit) | (to_en & to_sts);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (any_src) state_d = ST_RAISED;
            ST_RAISED: begin
                if (!any_src)       state_d = ST_IDLE;
                else if (ack_valid) state_d = ST_ACK;
            end
            ST_ACK:    if (!ack_valid) state_d = any_src ? ST_RAISED : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            line_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RAISED && state_d == ST_ACK) begin
                slot_q <= ack_slot;
                line_q <= ack_line;
            end
        end
    end

    always_comb begin
        irq_n    = 1'b1;
        sel_n    = '1;
        sel_line = 1'b0;
        unique case (state_q)
            ST_IDLE:   irq_n = 1'b1;
            ST_RAISED: irq_n = 1'b0;
            ST_ACK: begin
                irq_n    = 1'b0;
                sel_line = line_q;
                for (int s = 0; s < SLOTS; s++)
                    if (slot_q == SW'(s)) sel_n[s] = 1'b0;
            end
            default:   irq_n = 1'b1;
        endcase
    end

    assign irq_on = ~irq_n;

    a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
        any_src |=> !irq_n) else $error("R4 raise");
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> !$past(any_src)) else $error("R5 release");
    a_r9_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n)) else $error("R9 select one-hot");
    a_r10_sel_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n != '1) |-> $past(ack_valid)) else $error("R10 select without ack");
endmodule

// File: rtl/intagg_top.sv
module intagg_top
    import intagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  req_n,
    input  logic              timeout_evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ack_valid,
    input  logic [SLOT_W-1:0] ack_slot,
    input  logic              ack_line,
    output logic              irq_n,
    output logic [N_SLOTS-1:0] sel_n,
    output logic              sel_line
);
    logic [N_REQ-1:0]   pend;
    logic [N_SLOTS-1:0] slot_en;
    logic               to_en, to_sts, irq_on;

    intagg_sync #(.WIDTH(N_REQ), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .pend(pend)
    );

    intagg_regs #(.SLOTS(N_SLOTS), .REQS(N_REQ)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .pend(pend), .irq_on(irq_on),
        .timeout_evt(timeout_evt), .rdata(reg_rdata),
        .slot_en(slot_en), .to_en(to_en), .to_sts(to_sts)
    );

    intagg_fsm #(.SLOTS(N_SLOTS), .LINES(N_LINES), .SW(SLOT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pend(pend), .slot_en(slot_en),
        .to_en(to_en), .to_sts(to_sts), .ack_valid(ack_valid),
        .ack_slot(ack_slot), .ack_line(ack_line), .irq_n(irq_n),
        .irq_on(irq_on), .sel_n(sel_n), .sel_line(sel_line)
    );
endmodule

// File: tb/sim_intagg_top.sv
`timescale 1ns/1ps
module sim_intagg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req_n = 8'hFF;
    logic        timeout_evt = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        ack_valid = 1'b0;
    logic [1:0]  ack_slot = 2'd0;
    logic        ack_line = 1'b0;
    logic        irq_n;
    logic [3:0]  sel_n;
    logic        sel_line;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intagg_top u0 (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .timeout_evt(timeout_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_slot(ack_slot),
        .ack_line(ack_line), .irq_n(irq_n), .sel_n(sel_n), .sel_line(sel_line)
    );

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        tick(2);
        // R1 reset state
        chk("R1 irq_n", {15'b0, irq_n}, 16'h1);
        chk("R1 sel_n", {12'b0, sel_n}, 16'hF);
        rd_reg(2'd0, rd); chk("R1 ctrl", rd, 16'h0);
        rd_reg(2'd2, rd); chk("R1 status", rd, 16'h0);
        rst_n = 1'b1;
        tick();

        // R2 R3 R4 R5 R6: sweep every source against every enable mask
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 16; m++) begin
                logic exp_on;
                exp_on = m[i/2];
                wr_reg(2'd0, 16'(m));
                req_n = ~(8'h1 << i);
                tick(2);
                rd_reg(2'd1, rd);
                chk("R2 pending", {8'b0, rd[7:0]}, 16'(8'h1 << i));
                chk("R4 not early", {15'b0, irq_n}, 16'h1);
                tick();
                chk("R3 gate", {15'b0, irq_n}, {15'b0, !exp_on});
                rd_reg(2'd1, rd);
                chk("R6 summary", {15'b0, rd[15]}, {15'b0, exp_on});
                req_n = 8'hFF;
                tick(3);
                chk("R5 release", {15'b0, irq_n}, 16'h1);
            end
        end

        // R5 hold while a second enabled source remains
        wr_reg(2'd0, 16'h000F);
        req_n = 8'b1101_1110;
        tick(3);
        chk("R4 two src", {15'b0, irq_n}, 16'h0);
        req_n = 8'b1101_1111;
        tick(3);
        chk("R5 hold", {15'b0, irq_n}, 16'h0);
        req_n = 8'hFF;
        tick(2);
        chk("R5 last edge", {15'b0, irq_n}, 16'h0);
        tick();
        chk("R5 released", {15'b0, irq_n}, 16'h1);

        // R7 R8 timeout
        wr_reg(2'd0, 16'h0000);
        timeout_evt = 1'b1; tick(); timeout_evt = 1'b0;
        rd_reg(2'd2, rd); chk("R7 set", rd, 16'h1);
        tick(2);
        chk("R8 gated off", {15'b0, irq_n}, 16'h1);
        wr_reg(2'd2, 16'h0000);
        rd_reg(2'd2, rd); chk("R7 write0 keeps", rd, 16'h1);
        wr_reg(2'd0, 16'h0100);
        chk("R8 not early", {15'b0, irq_n}, 16'h1);
        tick();
        chk("R8 enabled", {15'b0, irq_n}, 16'h0);
        wr_reg(2'd2, 16'h0001);
        rd_reg(2'd2, rd); chk("R7 w1c", rd, 16'h0);
        tick();
        chk("R8 release", {15'b0, irq_n}, 16'h1);
        timeout_evt = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h1;
        tick();
        timeout_evt = 1'b0; reg_wr = 1'b0;
        rd_reg(2'd2, rd); chk("R7 set wins", rd, 16'h1);
        wr_reg(2'd2, 16'h0001);
        wr_reg(2'd0, 16'h0000);
        tick(2);

        // R9 acknowledge sweep
        wr_reg(2'd0, 16'h000F);
        for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < 2; l++) begin
                req_n = ~(8'h1 << (2*s + l));
                tick(3);
                ack_valid = 1'b1; ack_slot = 2'(s); ack_line = 1'(l);
                chk("R9 before ack", {12'b0, sel_n}, 16'hF);
                tick();
                chk("R9 sel_n", {12'b0, sel_n}, 16'(~(4'h1 << s) & 4'hF));
                chk("R9 sel_line", {15'b0, sel_line}, 16'(l));
                ack_slot = 2'(3 - s);
                tick();
                chk("R9 held", {12'b0, sel_n}, 16'(~(4'h1 << s) & 4'hF));
                chk("R5 irq in ack", {15'b0, irq_n}, 16'h0);
                ack_valid = 1'b0;
                tick();
                chk("R9 released", {12'b0, sel_n}, 16'hF);
                chk("R5 still low", {15'b0, irq_n}, 16'h0);
                req_n = 8'hFF;
                tick(3);
            end
        end

        // R10 ack while idle
        ack_valid = 1'b1; ack_slot = 2'd1;
        tick(2);
        chk("R10 ignored", {12'b0, sel_n}, 16'hF);
        chk("R10 irq", {15'b0, irq_n}, 16'h1);
        ack_valid = 1'b0;

        // R11 unused address and read-only pending
        rd_reg(2'd3, rd); chk("R11 addr3", rd, 16'h0);
        wr_reg(2'd1, 16'hFFFF);
        tick();
        rd_reg(2'd1, rd); chk("R11 pend ro", rd, 16'h0);
        chk("R11 irq", {15'b0, irq_n}, 16'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule